// File: doc/BRIEF.md
# Second-Order Recursive Filter with Fixed-Point Alignment

This block is a two-pole recursive filter for a stream of signed samples. One new sample arrives on every clock edge. The filter first scales each sample by a fractional gain. It then subtracts a weighted sum of its own two previous results and presents that difference on a registered output.

All three coefficients are build-time parameters in a signed fixed-point format with a parameterised binary point: 10 bits wide with 6 fractional bits by default. The feedback products carry twice as many fractional bits as the scaled input. They are therefore shifted right by the coefficient binary point before the subtraction, so that both operands have the same format.

The feedback is held in a transposed form. The older product waits one stage and is then added to the newer product, which keeps the recursion at one multiply and one add per cycle. A parameter selects where the shift happens: once on the summed feedback (the default), or on each product before the sum.

Top module: `iir2_allpole`

## Requirements
- R1: A synchronous active-high reset clears the output and all filter history. While reset is held, the output reads 0 whatever the input does.
- R2: A sample present at the input before clock edge k reaches the output after edge k+1. With empty history, that output equals the sample times the scale coefficient A0, read as a value with 6 fractional bits.
- R3: With the default alignment, the output sequence is d[n] = A0*x[n] - floor((A1*d[n-1] + A2*d[n-2]) / 64). The output is a 19-bit two's complement value with 6 fractional bits.
- R4: The right shift of the feedback rounds toward minus infinity. A feedback sum of -3696 contributes -58, not -57.
- R5: Feedback carries exactly two past results: the most recent through A1 and the one before through A2. Zero input with zero history keeps the output at zero.
- R6: Asserting reset in the middle of a stream discards all history. The first results after release depend only on samples given after release.
- R7: With the default coefficients (A0=48, A1=-77, A2=32), full-scale inputs of 127 and -128, held or stepped between, produce exact results with no internal wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample is taken on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 8 | Signed input sample, integer format |
| y_out | output | 19 | Registered signed filter result, 6 fractional bits |

## Verification
The hardest case to reach from the ports is a negative feedback sum whose low six bits are not zero. Only there does rounding toward minus infinity differ from truncation toward zero. A unit impulse reaches it on the second result, because -77 times 48 leaves a remainder. The pseudo-random stretch, the full-scale steps and the decaying tails reach it many more times, with both signs.

A reset issued partway through a ringing response shows whether any history survives into the next impulse response.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

    localparam int DEF_IN_W    = 8;
    localparam int DEF_COEF_W  = 10;
    localparam int DEF_COEF_BP = 6;

    localparam int DEF_A0 = 48;
    localparam int DEF_A1 = -77;
    localparam int DEF_A2 = 32;

    typedef enum logic {
        ALIGN_SUM   = 1'b0,
        ALIGN_TERMS = 1'b1
    } fb_align_e;

    function automatic int scaled_width(input int in_w, input int coef_w);
        return in_w + coef_w;
    endfunction

    function automatic int diff_width(input int in_w, input int coef_w);
        return in_w + coef_w + 1;
    endfunction

    function automatic int product_width(input int dif_w, input int coef_w);
        return dif_w + coef_w;
    endfunction

endpackage

// File: rtl/iir2_scale.sv
module iir2_scale
    import iir2_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter logic signed [COEF_W-1:0] A0 = COEF_W'(DEF_A0),
    localparam int M0_W  = scaled_width(IN_W, COEF_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] x_in,
    output logic signed [M0_W-1:0] m0
);

    logic signed [IN_W-1:0] in_reg;
    logic                   scale_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_reg   <= '0;
            scale_ok <= 1'b0;
        end else begin
            in_reg   <= x_in;
            scale_ok <= 1'b1;
        end
    end

    assign m0 = M0_W'(in_reg) * M0_W'(A0);

    AST_SCALE_INPUT: assert property (@(posedge clk) disable iff (rst)
        scale_ok |-> (m0 == M0_W'($past(x_in)) * M0_W'(A0))); // R2

endmodule

// File: rtl/iir2_diff.sv
module iir2_diff #(
    parameter int M0_W  = 18,
    parameter int FB_W  = 24,
    parameter int DIF_W = 19
) (
    input  logic signed [M0_W-1:0]  m0,
    input  logic signed [FB_W-1:0]  fb,
    output logic signed [DIF_W-1:0] dif
);

    // Both operands carry the coefficient binary point; the result keeps
    // the low DIF_W bits of the two's complement difference.
    assign dif = DIF_W'(FB_W'(m0) - fb);

endmodule

// File: rtl/iir2_fbk.sv
module iir2_fbk
    import iir2_pkg::*;
#(
    parameter int DIF_W   = 19,
    parameter int COEF_W  = DEF_COEF_W,
    parameter int COEF_BP = DEF_COEF_BP,
    parameter logic signed [COEF_W-1:0] A1 = COEF_W'(DEF_A1),
    parameter logic signed [COEF_W-1:0] A2 = COEF_W'(DEF_A2),
    parameter fb_align_e ALIGN = ALIGN_SUM,
    localparam int PROD_W = product_width(DIF_W, COEF_W),
    localparam int ACC_W  = PROD_W + 1,
    localparam int FB_W   = ACC_W - COEF_BP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [DIF_W-1:0] dif,
    output logic signed [FB_W-1:0]  fb
);

    localparam int TERM_W = PROD_W - COEF_BP;
    localparam int EXT_W  = ACC_W + 2;

    logic signed [PROD_W-1:0] m1;
    logic signed [PROD_W-1:0] m2;

    assign m1 = PROD_W'(dif) * PROD_W'(A1);
    assign m2 = PROD_W'(dif) * PROD_W'(A2);

    generate
        if (ALIGN == ALIGN_SUM) begin : g_sum
            logic signed [ACC_W-1:0]  p1;
            logic signed [PROD_W-1:0] p2;

            always_ff @(posedge clk) begin
                if (rst) begin
                    p1 <= '0;
                    p2 <= '0;
                end else begin
                    p1 <= ACC_W'(m1) + ACC_W'(p2);
                    p2 <= m2;
                end
            end

            assign fb = p1[ACC_W-1:COEF_BP];

            AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
                (dif == '0 && p1 == '0 && p2 == '0) |=> (p1 == '0 && p2 == '0)); // R5
        end else begin : g_terms
            logic signed [TERM_W-1:0] t1;
            logic signed [TERM_W-1:0] t2;
            logic signed [FB_W-1:0]   p1;
            logic signed [TERM_W-1:0] p2;

            assign t1 = m1[PROD_W-1:COEF_BP];
            assign t2 = m2[PROD_W-1:COEF_BP];

            always_ff @(posedge clk) begin
                if (rst) begin
                    p1 <= '0;
                    p2 <= '0;
                end else begin
                    p1 <= FB_W'(t1) + FB_W'(p2);
                    p2 <= t2;
                end
            end

            assign fb = p1;

            AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
                (dif == '0 && p1 == '0 && p2 == '0) |=> (p1 == '0 && p2 == '0)); // R5
        end
    endgenerate

    // Checking state: exact feedback rebuilt from the two previous differences.
    logic signed [DIF_W-1:0] dif_d1;
    logic signed [DIF_W-1:0] dif_d2;
    logic                    hist_ok;
    logic signed [EXT_W-1:0] fb_exact;
    logic signed [EXT_W-1:0] fb_lo;

    localparam logic signed [EXT_W-1:0] ERR_BOUND =
        (ALIGN == ALIGN_SUM) ? EXT_W'(1 << COEF_BP) : EXT_W'(2 << COEF_BP);

    always_ff @(posedge clk) begin
        if (rst) begin
            dif_d1  <= '0;
            dif_d2  <= '0;
            hist_ok <= 1'b0;
        end else begin
            dif_d1  <= dif;
            dif_d2  <= dif_d1;
            hist_ok <= 1'b1;
        end
    end

    assign fb_exact = EXT_W'(dif_d1) * EXT_W'(A1) + EXT_W'(dif_d2) * EXT_W'(A2);
    assign fb_lo    = EXT_W'(fb) <<< COEF_BP;

    AST_FEEDBACK_FLOOR: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> ((fb_exact >= fb_lo) && ((fb_exact - fb_lo) < ERR_BOUND))); // R4

endmodule

// File: rtl/iir2_allpole.sv
module iir2_allpole
    import iir2_pkg::*;
#(
    parameter int IN_W    = DEF_IN_W,
    parameter int COEF_W  = DEF_COEF_W,
    parameter int COEF_BP = DEF_COEF_BP,
    parameter logic signed [COEF_W-1:0] A0 = COEF_W'(DEF_A0),
    parameter logic signed [COEF_W-1:0] A1 = COEF_W'(DEF_A1),
    parameter logic signed [COEF_W-1:0] A2 = COEF_W'(DEF_A2),
    parameter fb_align_e ALIGN = ALIGN_SUM,
    localparam int OUT_W = diff_width(IN_W, COEF_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  x_in,
    output logic signed [OUT_W-1:0] y_out
);

    localparam int M0_W   = scaled_width(IN_W, COEF_W);
    localparam int DIF_W  = OUT_W;
    localparam int PROD_W = product_width(DIF_W, COEF_W);
    localparam int FB_W   = PROD_W + 1 - COEF_BP;

    logic signed [M0_W-1:0]  m0;
    logic signed [FB_W-1:0]  fb;
    logic signed [DIF_W-1:0] dif;

    iir2_scale #(
        .IN_W   (IN_W),
        .COEF_W (COEF_W),
        .A0     (A0)
    ) u_scale (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_in),
        .m0   (m0)
    );

    iir2_diff #(
        .M0_W  (M0_W),
        .FB_W  (FB_W),
        .DIF_W (DIF_W)
    ) u_diff (
        .m0  (m0),
        .fb  (fb),
        .dif (dif)
    );

    iir2_fbk #(
        .DIF_W   (DIF_W),
        .COEF_W  (COEF_W),
        .COEF_BP (COEF_BP),
        .A1      (A1),
        .A2      (A2),
        .ALIGN   (ALIGN)
    ) u_fbk (
        .clk (clk),
        .rst (rst),
        .dif (dif),
        .fb  (fb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_out <= '0;
        end else begin
            y_out <= dif;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (y_out == '0)); // R1

    AST_HISTORY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fb == '0)); // R6

    AST_HISTORY_EMPTY_NEXT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> (fb == '0)); // R6

endmodule

// File: tb/tb_iir2_allpole.sv
module tb_iir2_allpole;

    localparam int CLK_PERIOD = 10;
    localparam int MA0 = 48;
    localparam int MA1 = -77;
    localparam int MA2 = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [7:0]  x_in = '0;
    logic signed [18:0] y_out;

    int total = 0;
    int fails = 0;
    int exp_q[$];
    int dm1 = 0;
    int dm2 = 0;
    logic [31:0] seed = 32'h1234_5678;

    iir2_allpole #(
        .IN_W    (8),
        .COEF_W  (10),
        .COEF_BP (6),
        .A0      (10'sd48),
        .A1      (-10'sd77),
        .A2      (10'sd32)
    ) dut (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .y_out (y_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int floor_div64(input int s);
        int q;
        q = s / 64;
        if ((s % 64 != 0) && (s < 0)) q = q - 1;
        return q;
    endfunction

    task automatic check(input string tag, input int expv);
        total++;
        if (int'(y_out) != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, int'(y_out), expv);
        end
    endtask

    // Check the output due now, then present the next sample.
    task automatic step(input int xv, input string tag);
        int d;
        @(negedge clk);
        check(tag, exp_q.pop_front());
        rst  = 1'b0;
        x_in = 8'(xv);
        d = MA0 * xv - floor_div64(MA1 * dm1 + MA2 * dm2);
        dm2 = dm1;
        dm1 = d;
        exp_q.push_back(d);
    endtask

    task automatic apply_reset(input string tag);
        @(negedge clk);
        rst  = 1'b1;
        x_in = 8'sd99;
        repeat (2) @(negedge clk);
        check(tag, 0);
        x_in = -8'sd77;
        @(negedge clk);
        check(tag, 0);
        exp_q.delete();
        exp_q.push_back(0);
        exp_q.push_back(0);
        dm1 = 0;
        dm2 = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        fails++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

    initial begin
        // R1: output held at zero during reset, input ignored
        apply_reset("R1");

        // R2 then R4: unit impulse, second result needs floor of -3696/64
        step(1, "R2");
        step(0, "R2");
        step(0, "R2");
        step(0, "R4");
        for (int i = 0; i < 20; i++) step(0, "R5");

        // R7: held full-scale values and large steps
        for (int i = 0; i < 40; i++) step(127, "R7");
        for (int i = 0; i < 40; i++) step(-128, "R7");
        for (int i = 0; i < 20; i++) step(127, "R7");

        // R3: alternating and pseudo-random samples
        for (int i = 0; i < 20; i++) step((i % 2 == 0) ? 100 : -100, "R3");
        for (int i = 0; i < 200; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(int'(seed[23:16]) - 128, "R3");
        end

        // R6: reset during ringing, then a fresh impulse
        for (int i = 0; i < 3; i++) step(-128, "R6");
        apply_reset("R1");
        step(5, "R6");
        for (int i = 0; i < 12; i++) step(0, "R6");

        // R5: quiet input keeps quiet output, and flushes pending results
        for (int i = 0; i < 30; i++) step(0, "R5");

        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule